// File: doc/BRIEF.md
# Host I/O Port Command Decoder

This block is the host-facing control logic of a plug-in coprocessor card that sits on a byte-wide I/O bus. It claims a 32-port window at 0x300–0x31F and decodes host read and write strobes into register accesses. The block has two jobs. In transfer mode the host loads a 16-bit address counter and then streams bytes to or from the on-card SRAM through a data port. Each data access moves the counter forward by one. Write data and its address pass through a latch stage. In launch mode the host captures the counter value as a program start vector while the processor is held in reset, and then releases the processor to execute from that vector. The vector may point into EPROM or SRAM; the block does not interpret it.

Host strobes `io_wr_i` and `io_rd_i` are single-cycle pulses. Two strobes must be separated by at least one idle cycle. The SRAM is treated as asynchronous: `sram_rdata_i` follows `sram_addr_o` within the same cycle.

Top module: `hostio_cmd_dec`

## Requirements
- R1: Strobes whose address lies outside 0x300–0x31F change no state and leave `io_rdata_o` unchanged.
- R2: Writing offset 0x00 loads counter bits 7:0, and writing offset 0x01 loads bits 15:8. Reading those offsets returns the same bytes.
- R3: A data-port (offset 0x02) write makes `sram_we_o` high for exactly the next cycle. During that cycle `sram_addr_o` equals the counter value at the time of the strobe and `sram_wdata_o` equals the strobe data. The counter then reads one higher.
- R4: A data-port read raises `sram_re_o` in the strobe cycle with `sram_addr_o` equal to the counter. `io_rdata_o` shows the SRAM byte from the following cycle, and the counter advances by one.
- R5: The counter wraps from 0xFFFF to 0x0000 on a data access.
- R6: Writing 1 to the command register (offset 0x03) enters hold mode. `cpu_rst_o` is 1 and `cpu_vec_o` takes the current counter value.
- R7: Writing command 2 in hold mode enters run mode with `cpu_rst_o` = 0. Command 2 written in transfer mode is ignored.
- R8: Writing command 0 enters transfer mode with `cpu_rst_o` = 1. Command values above 2 are ignored.
- R9: While in run mode, data-port accesses raise neither `sram_we_o` nor `sram_re_o`, leave the counter unchanged, and read as 0x00.
- R10: Status (offset 0x04) reads bit 7 = 1 in run mode, bits 1:0 = mode code (0 transfer, 1 hold, 2 run), and all other bits 0. The command offset reads the mode code. Offsets 0x05–0x1F read 0x00.
- R11: After reset the block is in transfer mode with `cpu_rst_o` = 1, `cpu_vec_o` = 0, counter 0, `io_rdata_o` = 0, and both SRAM strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | 10 | Host I/O address |
| io_wr_i | input | 1 | Host write strobe, one cycle |
| io_rd_i | input | 1 | Host read strobe, one cycle |
| io_wdata_i | input | 8 | Host write data |
| io_rdata_o | output | 8 | Host read data, valid the cycle after a read strobe |
| sram_addr_o | output | 16 | SRAM address |
| sram_wdata_o | output | 8 | SRAM write data |
| sram_we_o | output | 1 | SRAM write enable |
| sram_re_o | output | 1 | SRAM read enable |
| sram_rdata_i | input | 8 | SRAM read data |
| cpu_rst_o | output | 1 | Processor reset, active high |
| cpu_vec_o | output | 16 | Processor start vector |

## Verification
The bench probes both edges of the window: 0x2FF, 0x320 and a read at 0x323. A design with a loose decode would reload the counter from these accesses or overwrite the read latch. The counter is driven to 0xFFFF before a data write. A wrong carry would leave the high byte set, or would address the wrong SRAM cell. Command 2 is issued from transfer mode, and an undefined command value is issued as well. A design that accepts either one would release the processor without a latched vector. Data-port traffic is sent during run mode. A design that misses the gate would raise SRAM strobes or move the counter under a running processor.

// File: rtl/hostio_pkg.sv
package hostio_pkg;
  typedef enum logic [1:0] {
    MODE_XFER = 2'd0,
    MODE_HOLD = 2'd1,
    MODE_RUN  = 2'd2
  } mode_e;

  localparam int unsigned OFF_CTR_LO = 0;
  localparam int unsigned OFF_CTR_HI = 1;
  localparam int unsigned OFF_DATA   = 2;
  localparam int unsigned OFF_CMD    = 3;
  localparam int unsigned OFF_STAT   = 4;

  localparam logic [7:0] CMD_XFER = 8'd0;
  localparam logic [7:0] CMD_HOLD = 8'd1;
  localparam logic [7:0] CMD_RUN  = 8'd2;
endpackage

// File: rtl/hostio_win_dec.sv
module hostio_win_dec #(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned WIN_BITS = 5,
  parameter logic [ADDR_W-1:0] BASE = 10'h300
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output logic                hit_o,
  output logic [WIN_BITS-1:0] off_o
);
  assign hit_o = (addr_i[ADDR_W-1:WIN_BITS] == BASE[ADDR_W-1:WIN_BITS]);
  assign off_o = addr_i[WIN_BITS-1:0];
endmodule

// File: rtl/hostio_addr_ctr.sv
module hostio_addr_ctr #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CTR_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_lo_i,
  input  logic              ld_hi_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              inc_i,
  output logic [CTR_W-1:0]  cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (ld_lo_i) cnt_o[BYTE_W-1:0] <= wdata_i;
    else if (ld_hi_i) cnt_o[CTR_W-1:BYTE_W] <= wdata_i;
    else if (inc_i)   cnt_o <= cnt_o + CTR_W'(1);
  end

  AST_CTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(inc_i && !ld_lo_i && !ld_hi_i) |-> cnt_o == $past(cnt_o) + CTR_W'(1)); // R5
endmodule

// File: rtl/hostio_mode_ctl.sv
module hostio_mode_ctl
  import hostio_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned VEC_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_wr_i,
  input  logic [BYTE_W-1:0] cmd_i,
  input  logic [VEC_W-1:0]  ctr_i,
  output mode_e             mode_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              cpu_rst_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= MODE_XFER;
      vec_o  <= '0;
    end else if (cmd_wr_i) begin
      if (cmd_i == BYTE_W'(CMD_XFER)) begin
        mode_o <= MODE_XFER;
      end else if (cmd_i == BYTE_W'(CMD_HOLD)) begin
        mode_o <= MODE_HOLD;
        vec_o  <= ctr_i;
      end else if (cmd_i == BYTE_W'(CMD_RUN) && mode_o == MODE_HOLD) begin
        mode_o <= MODE_RUN;
      end
    end
  end

  assign cpu_rst_o = (mode_o != MODE_RUN);

  AST_RUN_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_RUN && $past(mode_o) != MODE_RUN) |->
      $past(cmd_wr_i && cmd_i == BYTE_W'(CMD_RUN) && mode_o == MODE_HOLD)); // R7
  AST_VEC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_RUN && $past(mode_o) == MODE_RUN) |-> $stable(vec_o)); // R6
endmodule

// File: rtl/hostio_cmd_dec.sv
module hostio_cmd_dec
  import hostio_pkg::*;
#(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned WIN_BITS = 5,
  parameter logic [ADDR_W-1:0] BASE = 10'h300,
  parameter int unsigned BYTE_W   = 8,
  localparam int unsigned CTR_W   = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [BYTE_W-1:0] io_wdata_i,
  output logic [BYTE_W-1:0] io_rdata_o,
  output logic [CTR_W-1:0]  sram_addr_o,
  output logic [BYTE_W-1:0] sram_wdata_o,
  output logic              sram_we_o,
  output logic              sram_re_o,
  input  logic [BYTE_W-1:0] sram_rdata_i,
  output logic              cpu_rst_o,
  output logic [CTR_W-1:0]  cpu_vec_o
);
  logic                hit;
  logic [WIN_BITS-1:0] off;
  logic                wr_hit, rd_hit, busy;
  logic                data_wr, data_rd;
  logic [CTR_W-1:0]    ctr;
  logic [CTR_W-1:0]    wl_addr;
  logic [BYTE_W-1:0]   wl_data;
  logic                wl_vld;
  logic [BYTE_W-1:0]   rd_mux;
  mode_e               mode;

  hostio_win_dec #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .BASE(BASE)) u_dec (
    .addr_i(io_addr_i), .hit_o(hit), .off_o(off)
  );

  assign wr_hit  = io_wr_i && hit;
  assign rd_hit  = io_rd_i && hit;
  assign busy    = (mode == MODE_RUN);
  assign data_wr = wr_hit && off == WIN_BITS'(OFF_DATA) && !busy;
  assign data_rd = rd_hit && off == WIN_BITS'(OFF_DATA) && !busy;

  hostio_addr_ctr #(.BYTE_W(BYTE_W)) u_ctr (
    .clk_i, .rst_ni,
    .ld_lo_i(wr_hit && off == WIN_BITS'(OFF_CTR_LO)),
    .ld_hi_i(wr_hit && off == WIN_BITS'(OFF_CTR_HI)),
    .wdata_i(io_wdata_i),
    .inc_i(data_wr || data_rd),
    .cnt_o(ctr)
  );

  hostio_mode_ctl #(.BYTE_W(BYTE_W), .VEC_W(CTR_W)) u_mode (
    .clk_i, .rst_ni,
    .cmd_wr_i(wr_hit && off == WIN_BITS'(OFF_CMD)),
    .cmd_i(io_wdata_i),
    .ctr_i(ctr),
    .mode_o(mode),
    .vec_o(cpu_vec_o),
    .cpu_rst_o(cpu_rst_o)
  );

  // write latch: address and data held for the SRAM write cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wl_vld  <= 1'b0;
      wl_addr <= '0;
      wl_data <= '0;
    end else begin
      wl_vld <= data_wr;
      if (data_wr) begin
        wl_addr <= ctr;
        wl_data <= io_wdata_i;
      end
    end
  end

  assign sram_we_o    = wl_vld;
  assign sram_wdata_o = wl_data;
  assign sram_re_o    = data_rd;
  assign sram_addr_o  = wl_vld ? wl_addr : ctr;

  always_comb begin
    rd_mux = '0;
    case (off)
      WIN_BITS'(OFF_CTR_LO): rd_mux = ctr[BYTE_W-1:0];
      WIN_BITS'(OFF_CTR_HI): rd_mux = ctr[CTR_W-1:BYTE_W];
      WIN_BITS'(OFF_DATA):   rd_mux = busy ? '0 : sram_rdata_i;
      WIN_BITS'(OFF_CMD):    rd_mux = BYTE_W'(mode);
      WIN_BITS'(OFF_STAT): begin
        rd_mux[1:0]        = mode;
        rd_mux[BYTE_W-1]   = busy;
      end
      default:               rd_mux = '0;
    endcase
  end

  // read latch toward the host
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     io_rdata_o <= '0;
    else if (rd_hit) io_rdata_o <= rd_mux;
  end

  AST_WE_FROM_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_we_o |-> $past(io_wr_i && hit && off == WIN_BITS'(OFF_DATA) && mode != MODE_RUN)); // R3
  AST_RUN_NO_SRAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode) == MODE_RUN && mode == MODE_RUN) |-> !sram_we_o); // R9
  AST_OUTSIDE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!(io_rd_i && hit)) |-> $stable(io_rdata_o)); // R1
endmodule

// File: tb/sim_hostio_cmd_dec.sv
module sim_hostio_cmd_dec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic [15:0] sram_addr;
  logic [7:0]  sram_wdata, sram_rdata;
  logic        sram_we, sram_re, cpu_rst;
  logic [15:0] cpu_vec;
  logic [7:0]  mem [256];

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;

  always #10 clk = ~clk;

  hostio_cmd_dec u0 (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(io_addr), .io_wr_i(io_wr),
    .io_rd_i(io_rd), .io_wdata_i(io_wdata), .io_rdata_o(io_rdata),
    .sram_addr_o(sram_addr), .sram_wdata_o(sram_wdata), .sram_we_o(sram_we),
    .sram_re_o(sram_re), .sram_rdata_i(sram_rdata), .cpu_rst_o(cpu_rst),
    .cpu_vec_o(cpu_vec)
  );

  assign sram_rdata = mem[sram_addr[7:0]];
  always @(posedge clk) if (sram_we) mem[sram_addr[7:0]] <= sram_wdata;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic iow(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  // driver: queue the expected byte, the monitor compares it
  task automatic ior(input logic [9:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk); io_rd = 1'b0;
    idle();
  endtask

  always @(posedge clk) rd_seen <= io_rd && io_addr >= 10'h300 && io_addr <= 10'h31F;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, io_rdata, e);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 rst", cpu_rst, 1); chk("R11 vec", cpu_vec, 0);
    chk("R11 rdata", io_rdata, 0); chk("R11 we", sram_we, 0); chk("R11 re", sram_re, 0);
    rst_n = 1'b1;
    ior(10'h304, 8'h00, "R11 status");

    // R2 counter load and readback
    iow(10'h300, 8'h34); iow(10'h301, 8'h12);
    ior(10'h300, 8'h34, "R2 lo"); ior(10'h301, 8'h12, "R2 hi");

    // R3 data write through latch
    iow(10'h302, 8'hA5);
    chk("R3 we", sram_we, 1); chk("R3 addr", sram_addr, 16'h1234); chk("R3 data", sram_wdata, 8'hA5);
    idle(); chk("R3 we pulse", sram_we, 0);
    ior(10'h300, 8'h35, "R3 ctr inc");

    // R4 streamed writes then reads
    iow(10'h300, 8'h10); iow(10'h301, 8'h00);
    iow(10'h302, 8'h11); idle(); iow(10'h302, 8'h22); idle(); iow(10'h302, 8'h33); idle();
    iow(10'h300, 8'h10);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); io_addr = 10'h302; io_rd = 1'b1;
      exp_q.push_back(8'((k + 1) * 8'h11)); tag_q.push_back("R4 rdata");
      #1; chk("R4 re", sram_re, 1); chk("R4 addr", sram_addr, 16'h0010 + 16'(k));
      @(negedge clk); io_rd = 1'b0;
      idle();
    end
    ior(10'h300, 8'h13, "R4 ctr inc");

    // R1 outside window
    iow(10'h320, 8'h99); iow(10'h2FF, 8'h77);
    ior(10'h300, 8'h13, "R1 no load");
    @(negedge clk); io_addr = 10'h323; io_rd = 1'b1;
    @(negedge clk); io_rd = 1'b0;
    chk("R1 rdata held", io_rdata, 8'h13);

    // R5 wrap
    iow(10'h300, 8'hFF); iow(10'h301, 8'hFF);
    iow(10'h302, 8'h5A); chk("R5 addr", sram_addr, 16'hFFFF); idle();
    ior(10'h300, 8'h00, "R5 wrap lo"); ior(10'h301, 8'h00, "R5 wrap hi");

    // R10 unused offsets
    ior(10'h305, 8'h00, "R10 off5"); ior(10'h31F, 8'h00, "R10 off1F");

    // R7 / R8 ignored commands
    iow(10'h303, 8'h02); chk("R7 no run", cpu_rst, 1);
    ior(10'h304, 8'h00, "R7 status xfer");
    iow(10'h303, 8'h07); ior(10'h304, 8'h00, "R8 bad cmd");

    // R6 hold and latch vector
    iow(10'h300, 8'h00); iow(10'h301, 8'h08);
    iow(10'h303, 8'h01);
    chk("R6 rst", cpu_rst, 1); chk("R6 vec", cpu_vec, 16'h0800);
    ior(10'h304, 8'h01, "R6 status");

    // R7 run
    iow(10'h303, 8'h02); chk("R7 rst released", cpu_rst, 0);
    ior(10'h304, 8'h82, "R10 status run"); ior(10'h303, 8'h02, "R10 cmd readback");

    // R9 data port gated
    iow(10'h302, 8'hEE); chk("R9 no we", sram_we, 0);
    @(negedge clk); io_addr = 10'h302; io_rd = 1'b1;
    exp_q.push_back(8'h00); tag_q.push_back("R9 rdata zero");
    #1; chk("R9 no re", sram_re, 0);
    @(negedge clk); io_rd = 1'b0; idle();
    ior(10'h300, 8'h00, "R9 ctr held");
    chk("R9 vec held", cpu_vec, 16'h0800);

    // R8 back to transfer
    iow(10'h303, 8'h00); chk("R8 rst", cpu_rst, 1);
    ior(10'h304, 8'h00, "R8 status");

    repeat (3) idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule